// File: doc/BRIEF.md
# Separable-Layer Frequency Convolution Engine

This block performs the frequency half of a separable convolution layer in a keyword-spotting network. It reads the temporal layer's result out of a buffer RAM. It convolves each row with a three-tap kernel along the frequency axis, which fans the input channels out to a larger set of output channels. It writes the requantized activations into the next buffer RAM. Batch normalization has been absorbed offline into the constant kernel weights and one bias per output channel, so both enter the block only as parameters.

A single `start` pulse launches a full pass over the feature map. The input buffer is read through a window port: one address returns, on the next cycle, three neighbouring frequency columns of every input channel. A multiplier bank and adder produce one output element each clock. The sum, with its channel bias added, goes through three steps: low bits are dropped to reach the output scale, negative values are forced to zero, and values too large for the stored width are clamped. The result is then written to the output buffer. With the default sizes (59 rows by 13 frequency bins in, one input channel, eight output channels, 59 by 11 out) a pass takes 5192 writes, one per cycle.

Top module: `freqconv_top`

## Requirements
- R1: While `rst` is high, and from the first clock after it until a start, `wr_en`, `rd_en` and `done` are low.
- R2: A `start` sampled at a clock edge while idle is followed by a write in the second cycle after that edge. Then exactly COUT*ROWS*(W_IN-2) writes follow, one per cycle with no gap (5192 with the defaults).
- R3: Writes come in linear order, starting at address 0 and stepping by one. Address (oc*ROWS+row)*(W_IN-2)+col holds output channel oc, row row, frequency column col. Channel is the outermost loop and column the innermost.
- R4: For output (row, col) the block reads input address row*W_IN+col. The returned word carries column col+k of input channel ic in bits [(k*CIN+ic)*IN_W +: IN_W], for k in 0..2. The read data is used one cycle after `rd_en`.
- R5: The pre-quantization value is the signed sum, over k and ic, of input times weight, plus BIASES[oc*BIAS_W +: BIAS_W]. The weight sits at WEIGHTS[((oc*3+k)*CIN+ic)*W_W +: W_W]. All fields are two's complement.
- R6: Requantization shifts the sum right arithmetically by TRUNC bits, rounding toward minus infinity.
- R7: A shifted value of zero or less is stored as 0.
- R8: A shifted value above 2^(OUT_W-1)-1 (127 by default) is stored as that maximum. Smaller positive values are stored unchanged.
- R9: `done` is high for exactly one cycle, the cycle that carries the final write (address COUT*ROWS*(W_IN-2)-1).
- R10: `start` raised while a pass is running is ignored. The running pass neither restarts nor lengthens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (ignored while busy) |
| done | output | 1 | One-cycle pulse with the last write |
| rd_en | output | 1 | Input buffer read strobe |
| rd_addr | output | $clog2(ROWS*W_IN) | Input window address |
| rd_data | input | 3*CIN*IN_W | Three columns of all input channels, valid one cycle after `rd_en` |
| wr_en | output | 1 | Output buffer write strobe |
| wr_addr | output | $clog2(COUT*ROWS*(W_IN-2)) | Output buffer address |
| wr_data | output | OUT_W | Requantized, rectified activation |

## Verification
The hardest conditions to reach from the ports are the two ends of the requantizer: sums that clamp at the positive limit and sums that fall below zero. Mid-range values near the truncation boundary are hard to reach as well. The stimulus fills the input buffer with patterns of full 10-bit swing against weights of mixed sign and large magnitude, which pushes many outputs into clamping and many into the rectifier. A narrow-swing pattern keeps most sums inside the representable range, so the floor behaviour of the shift is visible. A second `start` is raised halfway through one pass, and a reset is applied in the middle of another, to show that the address walk is neither disturbed nor left running.

// File: rtl/freqconv_pkg.sv
package freqconv_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Bit width able to index n items (at least one bit)
    function automatic int idx_bits(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/freqconv_seq.sv
module freqconv_seq
    import freqconv_pkg::*;
#(
    parameter int COUT = 8,
    parameter int ROWS = 59,
    parameter int W_IN = 13,
    localparam int W_OUT = W_IN - 2,
    localparam int OC_W  = idx_bits(COUT),
    localparam int ROW_W = idx_bits(ROWS),
    localparam int COL_W = idx_bits(W_OUT),
    localparam int RA_W  = idx_bits(ROWS * W_IN),
    localparam int WA_W  = idx_bits(COUT * ROWS * W_OUT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output logic            rd_en,
    output logic [RA_W-1:0] rd_addr,
    output logic            s1_valid,
    output logic            s1_last,
    output logic [OC_W-1:0] s1_oc,
    output logic [WA_W-1:0] s1_idx
);

    typedef struct packed {
        phase_e            phase;
        logic [OC_W-1:0]   oc;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [RA_W-1:0]   addr;
        logic [WA_W-1:0]   idx;
        logic              v1;
        logic              last1;
        logic [OC_W-1:0]   oc1;
        logic [WA_W-1:0]   idx1;
    } seq_t;

    seq_t st_d, st_q;
    logic col_end, row_end, oc_end;

    always_comb begin
        st_d       = st_q;
        st_d.v1    = 1'b0;
        st_d.last1 = 1'b0;
        col_end    = (st_q.col == COL_W'(W_OUT - 1));
        row_end    = (st_q.row == ROW_W'(ROWS - 1));
        oc_end     = (st_q.oc  == OC_W'(COUT - 1));
        if (st_q.phase == PH_IDLE) begin
            if (start) begin
                st_d.phase = PH_RUN;
                st_d.oc    = '0;
                st_d.row   = '0;
                st_d.col   = '0;
                st_d.addr  = '0;
                st_d.idx   = '0;
            end
        end else begin
            st_d.v1    = 1'b1;
            st_d.oc1   = st_q.oc;
            st_d.idx1  = st_q.idx;
            st_d.last1 = col_end && row_end && oc_end;
            st_d.idx   = st_q.idx + WA_W'(1);
            if (!col_end) begin
                st_d.col  = st_q.col + COL_W'(1);
                st_d.addr = st_q.addr + RA_W'(1);
            end else begin
                st_d.col = '0;
                if (!row_end) begin
                    st_d.row  = st_q.row + ROW_W'(1);
                    // skip the two trailing columns that have no full window
                    st_d.addr = st_q.addr + RA_W'(W_IN - W_OUT + 1);
                end else begin
                    st_d.row  = '0;
                    st_d.addr = '0;
                    if (!oc_end) begin
                        st_d.oc = st_q.oc + OC_W'(1);
                    end else begin
                        st_d.oc    = '0;
                        st_d.phase = PH_IDLE;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rd_en    = (st_q.phase == PH_RUN);
    assign rd_addr  = st_q.addr;
    assign s1_valid = st_q.v1;
    assign s1_last  = st_q.last1;
    assign s1_oc    = st_q.oc1;
    assign s1_idx   = st_q.idx1;

    // R4: every window read starts early enough in its row to hold three columns
    a_r4_window_in_row: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> ((int'(rd_addr) % W_IN) <= W_IN - 3));

    // R10: once reading, the walk advances; a start cannot pull it back to zero mid-pass
    a_r10_no_rewind: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en) && rd_addr == '0) |-> ($past(int'(rd_addr)) == W_OUT - 1 + (ROWS - 1) * W_IN));

endmodule

// File: rtl/freqconv_mac.sv
module freqconv_mac #(
    parameter int CIN    = 1,
    parameter int COUT   = 8,
    parameter int IN_W   = 10,
    parameter int W_W    = 8,
    parameter int BIAS_W = 16,
    parameter int ACC_W  = 21,
    parameter int OC_W   = 3,
    parameter logic [COUT*3*CIN*W_W-1:0] WEIGHTS = '0,
    parameter logic [COUT*BIAS_W-1:0]    BIASES  = '0,
    localparam int NTAP   = 3 * CIN,
    localparam int PROD_W = IN_W + W_W
) (
    input  logic [NTAP*IN_W-1:0]    win,
    input  logic [OC_W-1:0]         oc,
    output logic signed [ACC_W-1:0] acc
);

    logic signed [PROD_W-1:0] prod [NTAP];
    logic signed [BIAS_W-1:0] bias_sel;

    // One constant-coefficient multiplier per tap; coefficient picked by channel
    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        logic signed [IN_W-1:0] x_sel;
        logic signed [W_W-1:0]  w_sel;
        assign x_sel   = win[t*IN_W +: IN_W];
        assign w_sel   = WEIGHTS[(int'(oc) * NTAP + t) * W_W +: W_W];
        assign prod[t] = x_sel * w_sel;
    end

    assign bias_sel = BIASES[int'(oc) * BIAS_W +: BIAS_W];

    always_comb begin
        acc = {{(ACC_W-BIAS_W){bias_sel[BIAS_W-1]}}, bias_sel};
        for (int t = 0; t < NTAP; t++) begin
            acc = acc + {{(ACC_W-PROD_W){prod[t][PROD_W-1]}}, prod[t]};
        end
    end

endmodule

// File: rtl/freqconv_requant.sv
module freqconv_requant #(
    parameter int ACC_W = 21,
    parameter int TRUNC = 10,
    parameter int OUT_W = 8,
    localparam int SH_W = ACC_W - TRUNC,
    localparam int MAXP = 2 ** (OUT_W - 1) - 1
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic [OUT_W-1:0]        q
);

    logic signed [SH_W-1:0] shifted;

    // dropping low bits of a two's complement value floors it
    assign shifted = acc[ACC_W-1:TRUNC];

    always_comb begin
        if (shifted <= 0)
            q = '0;
        else if (shifted > $signed(SH_W'(MAXP)))
            q = OUT_W'(MAXP);
        else
            q = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/freqconv_top.sv
module freqconv_top
    import freqconv_pkg::*;
#(
    parameter int CIN    = 1,
    parameter int COUT   = 8,
    parameter int ROWS   = 59,
    parameter int W_IN   = 13,
    parameter int IN_W   = 10,
    parameter int W_W    = 8,
    parameter int BIAS_W = 16,
    parameter int TRUNC  = 10,
    parameter int OUT_W  = 8,
    parameter logic [COUT*3*CIN*W_W-1:0] WEIGHTS = {(COUT*3*CIN){W_W'(1)}},
    parameter logic [COUT*BIAS_W-1:0]    BIASES  = '0,
    localparam int W_OUT  = W_IN - 2,
    localparam int NTAP   = 3 * CIN,
    localparam int TOTAL  = COUT * ROWS * W_OUT,
    localparam int OC_W   = idx_bits(COUT),
    localparam int RA_W   = idx_bits(ROWS * W_IN),
    localparam int WA_W   = idx_bits(TOTAL),
    localparam int PROD_W = IN_W + W_W,
    localparam int ACC_W  = ((PROD_W > BIAS_W) ? PROD_W : BIAS_W) + $clog2(NTAP + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    output logic                 done,
    output logic                 rd_en,
    output logic [RA_W-1:0]      rd_addr,
    input  logic [NTAP*IN_W-1:0] rd_data,
    output logic                 wr_en,
    output logic [WA_W-1:0]      wr_addr,
    output logic [OUT_W-1:0]     wr_data
);

    logic                    s1_valid, s1_last;
    logic [OC_W-1:0]         s1_oc;
    logic [WA_W-1:0]         s1_idx;
    logic signed [ACC_W-1:0] acc;
    logic [OUT_W-1:0]        q;

    freqconv_seq #(.COUT(COUT), .ROWS(ROWS), .W_IN(W_IN)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .s1_valid(s1_valid), .s1_last(s1_last), .s1_oc(s1_oc), .s1_idx(s1_idx)
    );

    freqconv_mac #(
        .CIN(CIN), .COUT(COUT), .IN_W(IN_W), .W_W(W_W), .BIAS_W(BIAS_W),
        .ACC_W(ACC_W), .OC_W(OC_W), .WEIGHTS(WEIGHTS), .BIASES(BIASES)
    ) u_mac (
        .win(rd_data), .oc(s1_oc), .acc(acc)
    );

    freqconv_requant #(.ACC_W(ACC_W), .TRUNC(TRUNC), .OUT_W(OUT_W)) u_rq (
        .acc(acc), .q(q)
    );

    typedef struct packed {
        logic             wr_en;
        logic [WA_W-1:0]  wr_addr;
        logic [OUT_W-1:0] wr_data;
        logic             done;
    } wr_t;

    wr_t out_d, out_q;

    always_comb begin
        out_d         = out_q;
        out_d.wr_en   = s1_valid;
        out_d.done    = s1_valid && s1_last;
        if (s1_valid) begin
            out_d.wr_addr = s1_idx;
            out_d.wr_data = q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign wr_en   = out_q.wr_en;
    assign wr_addr = out_q.wr_addr;
    assign wr_data = out_q.wr_data;
    assign done    = out_q.done;

    // R3: a burst of writes begins at address zero
    a_r3_first_at_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_en) |-> (wr_addr == '0));

    // R3: back-to-back writes step the address by one
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + WA_W'(1)));

    // R9: completion only accompanies the final write
    a_r9_done_on_last: assert property (@(posedge clk) disable iff (rst)
        done |-> (wr_en && wr_addr == WA_W'(TOTAL - 1)));

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: stored activations are never negative
    a_r7_nonneg: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !wr_data[OUT_W-1]);

    // R2: a write follows a read by exactly one stage
    a_r2_read_then_write: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> ##1 wr_en);

endmodule

// File: tb/tb_freqconv_top.sv
module tb_freqconv_top;

    localparam int CIN    = 1;
    localparam int COUT   = 8;
    localparam int ROWS   = 59;
    localparam int W_IN   = 13;
    localparam int W_OUT  = W_IN - 2;
    localparam int IN_W   = 10;
    localparam int W_W    = 8;
    localparam int BIAS_W = 16;
    localparam int TRUNC  = 10;
    localparam int OUT_W  = 8;
    localparam int NTAP   = 3 * CIN;
    localparam int TOTAL  = COUT * ROWS * W_OUT;
    localparam int MAXP   = 2 ** (OUT_W - 1) - 1;

    function automatic int wt(int oc, int k, int ic);
        return ((oc * 53 + (k * CIN + ic) * 29 + 7) % 255) - 127;
    endfunction

    function automatic int bs(int oc);
        return ((oc * 4001) % 16000) - 8000;
    endfunction

    function automatic logic [COUT*NTAP*W_W-1:0] pack_w();
        logic [COUT*NTAP*W_W-1:0] v;
        v = '0;
        for (int oc = 0; oc < COUT; oc++)
            for (int k = 0; k < 3; k++)
                for (int ic = 0; ic < CIN; ic++)
                    v[((oc*3 + k)*CIN + ic)*W_W +: W_W] = W_W'(wt(oc, k, ic));
        return v;
    endfunction

    function automatic logic [COUT*BIAS_W-1:0] pack_b();
        logic [COUT*BIAS_W-1:0] v;
        v = '0;
        for (int oc = 0; oc < COUT; oc++) v[oc*BIAS_W +: BIAS_W] = BIAS_W'(bs(oc));
        return v;
    endfunction

    localparam logic [COUT*NTAP*W_W-1:0] TB_W = pack_w();
    localparam logic [COUT*BIAS_W-1:0]   TB_B = pack_b();

    // pattern table: row multiplier, column multiplier, seed, modulus, second-start flag
    localparam int NPAT = 4;
    localparam int PAT [NPAT][5] = '{
        '{7, 3, 11, 1024, 0},
        '{13, 5, 0, 64, 0},
        '{3, 17, 101, 1024, 1},
        '{1, 1, 300, 256, 0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic done, rd_en, wr_en;
    logic [$clog2(ROWS*W_IN)-1:0] rd_addr;
    logic [NTAP*IN_W-1:0] rd_data = '0;
    logic [$clog2(TOTAL)-1:0] wr_addr;
    logic [OUT_W-1:0] wr_data;

    int mem_v [ROWS*W_IN*CIN];
    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    freqconv_top #(
        .CIN(CIN), .COUT(COUT), .ROWS(ROWS), .W_IN(W_IN), .IN_W(IN_W), .W_W(W_W),
        .BIAS_W(BIAS_W), .TRUNC(TRUNC), .OUT_W(OUT_W), .WEIGHTS(TB_W), .BIASES(TB_B)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .done(done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // input buffer model: window of three columns, one cycle latency
    always @(posedge clk) begin
        if (rd_en) begin
            for (int k = 0; k < 3; k++)
                for (int ic = 0; ic < CIN; ic++)
                    rd_data[(k*CIN + ic)*IN_W +: IN_W] <=
                        IN_W'(mem_v[(int'(rd_addr) + k)*CIN + ic]);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input int p);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < W_IN; c++)
                for (int ic = 0; ic < CIN; ic++)
                    mem_v[(r*W_IN + c)*CIN + ic] =
                        ((r*PAT[p][0] + c*PAT[p][1] + ic*5 + PAT[p][2]) % PAT[p][3]) - PAT[p][3]/2;
    endtask

    // expected value; cls: 0 in range, 1 rectified, 2 clamped
    function automatic int expect_out(int oc, int row, int col, output int cls);
        longint s;
        s = bs(oc);
        for (int k = 0; k < 3; k++)
            for (int ic = 0; ic < CIN; ic++)
                s += longint'(mem_v[(row*W_IN + col + k)*CIN + ic]) * wt(oc, k, ic);
        s = s >>> TRUNC;
        if (s <= 0) begin cls = 1; return 0; end
        if (s > MAXP) begin cls = 2; return MAXP; end
        cls = 0;
        return int'(s);
    endfunction

    task automatic run_pass(input int p, input bit second_start);
        int n, nwr, first, cls, ev;
        bit finished;
        fill(p);
        @(negedge clk);
        start = 1'b1;
        n = 0; nwr = 0; first = -1; finished = 1'b0;
        while (!finished && n < 7000) begin
            @(negedge clk);
            n++;
            start = (second_start && n == 500);
            if (wr_en) begin
                int oc, row, col;
                if (first < 0) first = n;
                chk(int'(wr_addr) == nwr, second_start ? "R3/R10 address order" : "R3 address order",
                    int'(wr_addr), nwr);
                oc  = nwr / (ROWS * W_OUT);
                row = (nwr / W_OUT) % ROWS;
                col = nwr % W_OUT;
                ev = expect_out(oc, row, col, cls);
                if (cls == 1)
                    chk(int'(wr_data) == ev, "R7 rectified output", int'(wr_data), ev);
                else if (cls == 2)
                    chk(int'(wr_data) == ev, "R8 clamped output", int'(wr_data), ev);
                else
                    chk(int'(wr_data) == ev, "R4/R5/R6 in-range output", int'(wr_data), ev);
                nwr++;
            end
            if (done) begin
                chk(wr_en == 1'b1, "R9 done with final write", int'(wr_en), 1);
                finished = 1'b1;
            end
        end
        start = 1'b0;
        chk(first == 3, "R2 first write latency", first, 3);
        chk(nwr == TOTAL, second_start ? "R2/R10 write count" : "R2 write count", nwr, TOTAL);
        chk(n == TOTAL + 2, "R2 writes without gap", n, TOTAL + 2);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!wr_en && !done, "R9/R10 quiet after pass", int'(wr_en) + int'(done), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!wr_en && !rd_en && !done, "R1 outputs low in reset",
            int'(wr_en) + int'(rd_en) + int'(done), 0);
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(!wr_en && !rd_en && !done, "R1 idle after reset",
                int'(wr_en) + int'(rd_en) + int'(done), 0);
        end

        for (int p = 0; p < NPAT; p++) run_pass(p, PAT[p][4] != 0);

        // reset in the middle of a pass
        fill(0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!wr_en && !rd_en && !done, "R1 reset aborts pass",
            int'(wr_en) + int'(rd_en) + int'(done), 0);
        rst = 1'b0;
        repeat (10) begin
            @(negedge clk);
            chk(!wr_en && !rd_en, "R1 stays idle after abort", int'(wr_en) + int'(rd_en), 0);
        end

        // a clean pass after the abort still starts from the beginning
        run_pass(1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule